// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Threshold

This block holds bytes that a serial bus engine receives until host software collects them. The engine offers one byte per cycle on a push strobe. The host reaches the queue through a small register port with four addresses. Reading the data address removes the oldest byte. Other addresses report how many bytes are stored, hold a programmable threshold, and give a status byte.

A level event tells the host that enough bytes are waiting. Both the fill-level register and the threshold register count from zero. The level register shows the stored count minus one. A threshold value N means "signal when N+1 bytes are held". The event is recomputed every cycle from the current count and threshold, so lowering the threshold can raise the event on the next edge without any new byte arriving. A synchronous soft flush drops all stored bytes and returns the threshold to zero.

Top module: `rxq_top`

## Requirements
- R1: After `rst`, the queue is empty. `rx_empty`=1, `rx_full`=0, `rx_full_evt`=0 and `rx_overflow`=0. The threshold reads 0 and the level register reads 8'hFF.
- R2: The queue holds up to 16 bytes and returns them in the order they were pushed. `rx_full` is 1 exactly when 16 bytes are stored.
- R3: Address 1 (fill level) reads the stored count minus one as an 8-bit value. It reads 8'hFF when the queue is empty and 8'h0F when it is full.
- R4: Address 2 (threshold) stores bits [3:0] of the written byte and reads back with bits [7:4] zero. The written upper bits have no effect.
- R5: `rx_full_evt` is 1 exactly while the stored count is at least threshold+1. It follows the current count and threshold every cycle, and it is always 1 when the queue is full.
- R6: Address 3 (status) reads bit 6 = empty, bit 5 = full, bit 0 = overflow, and all other bits 0. The `rx_empty` and `rx_full` ports carry the same empty and full flags.
- R7: With the host read strobe active, address 0 returns the oldest byte combinationally and removes it at the clock edge. A data read while the queue is empty returns the byte most recently removed (0 after reset) and changes nothing.
- R8: A push while 16 bytes are held and no data read occurs in the same cycle is dropped. It sets `rx_overflow`, which stays set until `rst` or a soft flush.
- R9: `soft_flush` empties the queue, sets the threshold to 0 and clears overflow. It takes precedence over a push, a data read or a register write in the same cycle.
- R10: A push and a data read in the same cycle on a full queue both take effect, so the count stays at 16 and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_flush | input | 1 | Synchronous flush of contents and threshold |
| push_valid | input | 1 | Bus engine presents a received byte |
| push_data | input | 8 | Received byte |
| reg_rd | input | 1 | Host read strobe; on address 0 it removes a byte |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | 0 data, 1 fill level, 2 threshold, 3 status |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| rx_full_evt | output | 1 | Level event: count has reached threshold+1 |
| rx_empty | output | 1 | No bytes stored |
| rx_full | output | 1 | 16 bytes stored |
| rx_overflow | output | 1 | Sticky: a byte was dropped |

## Verification
The bench aims at the off-by-one edges of the zero-based encodings. It checks that the level register reads 8'hFF when empty and 8'h0F when full, and that threshold 15 fires only at 16 bytes. A design that compared the count directly with the threshold would fire one byte early. It also reads an empty queue and checks that the last removed byte comes back unchanged with the pointers held. A design that let the pointers wrap there would return stale data in later reads. It then pushes into a full queue, both alone and together with a data read. A wrong design would either lose the simultaneous byte or raise overflow falsely. Finally it lowers the threshold below the current count, and checks that a flush resets the threshold and clears overflow.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        RA_DATA  = 2'd0,
        RA_LEVEL = 2'd1,
        RA_THRSH = 2'd2,
        RA_STAT  = 2'd3
    } rxq_addr_e;

    localparam int ST_EMPTY_BIT = 6;
    localparam int ST_FULL_BIT  = 5;
    localparam int ST_OVF_BIT   = 0;

    typedef struct packed {
        logic empty;
        logic full;
        logic overflow;
    } rxq_flags_t;

    function automatic logic [REG_W-1:0] status_byte(input rxq_flags_t f);
        logic [REG_W-1:0] s;
        s = '0;
        s[ST_EMPTY_BIT] = f.empty;
        s[ST_FULL_BIT]  = f.full;
        s[ST_OVF_BIT]   = f.overflow;
        return s;
    endfunction

    // zero-based fill level: stored count minus one, wraps to all ones when empty
    function automatic logic [REG_W-1:0] level_code(input logic [REG_W-1:0] cnt);
        return cnt - 1'b1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  slot_we;

    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign slot_we[i] = wr_en && (wr_ptr == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop_req,
    output logic             do_push,
    output logic             do_pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic is_full;
    logic is_empty;

    assign is_full  = (count == CNT_MAX);
    assign is_empty = (count == '0);
    assign do_pop   = pop_req && !is_empty && !flush;
    assign do_push  = push && !flush && (!is_full || do_pop);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !do_push) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [DATA_W-1:0] head_data,
    input  logic              do_pop,
    input  logic [CNT_W-1:0]  count,
    input  rxq_flags_t        flags,
    output logic              pop_req,
    output logic              thr_evt,
    output logic [REG_W-1:0]  reg_rdata
);

    rxq_addr_e         addr;
    logic [PTR_W-1:0]  thresh;
    logic [DATA_W-1:0] last_val;
    logic              unused_wdata_hi;

    assign addr            = rxq_addr_e'(reg_addr);
    assign pop_req         = reg_rd && (addr == RA_DATA);
    assign unused_wdata_hi = ^reg_wdata[REG_W-1:PTR_W];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            thresh <= '0;
        end else if (reg_wr && addr == RA_THRSH) begin
            thresh <= reg_wdata[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_val <= '0;
        end else if (do_pop) begin
            last_val <= head_data;
        end
    end

    assign thr_evt = (count != '0) && (count >= ({1'b0, thresh} + 1'b1));

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            RA_DATA:  reg_rdata = REG_W'(flags.empty ? last_val : head_data);
            RA_LEVEL: reg_rdata = level_code(REG_W'(count));
            RA_THRSH: reg_rdata = REG_W'(thresh);
            RA_STAT:  reg_rdata = status_byte(flags);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_flush,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              rx_full_evt,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_overflow
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic              do_push;
    logic              do_pop;
    logic              pop_req;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] head_data;
    rxq_flags_t        flags;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (do_push),
        .wr_ptr  (wr_ptr),
        .wr_data (push_data),
        .rd_ptr  (rd_ptr),
        .rd_data (head_data)
    );

    rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .flush    (soft_flush),
        .push     (push_valid),
        .pop_req  (pop_req),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .overflow (rx_overflow)
    );

    assign flags.empty    = (count == '0);
    assign flags.full     = (count == CNT_W'(DEPTH));
    assign flags.overflow = rx_overflow;

    rxq_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .flush     (soft_flush),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .head_data (head_data),
        .do_pop    (do_pop),
        .count     (count),
        .flags     (flags),
        .pop_req   (pop_req),
        .thr_evt   (rx_full_evt),
        .reg_rdata (reg_rdata)
    );

    assign rx_empty = flags.empty;
    assign rx_full  = flags.full;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_flush,
    input logic       push_valid,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       rx_full_evt,
    input logic       rx_empty,
    input logic       rx_full,
    input logic       rx_overflow
);

    logic data_rd;
    assign data_rd = reg_rd && (reg_addr == 2'd0);

    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_empty && rx_full));

    // R5
    evt_on_full_chk: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> rx_full_evt);

    // R5
    evt_off_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> !rx_full_evt);

    // R8
    ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && rx_full && !data_rd && !soft_flush) |=> rx_overflow);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_overflow && !soft_flush) |=> rx_overflow);

    // R10
    full_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && rx_full && data_rd && !soft_flush && !rx_overflow)
        |=> (rx_full && !rx_overflow));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_flush |=> (rx_empty && !rx_overflow && !rx_full_evt));

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && data_rd && !push_valid && !soft_flush) |=> rx_empty);

endmodule

bind rxq_top rxq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .soft_flush  (soft_flush),
    .push_valid  (push_valid),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .rx_full_evt (rx_full_evt),
    .rx_empty    (rx_empty),
    .rx_full     (rx_full),
    .rx_overflow (rx_overflow)
);

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_flush = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_full_evt, rx_empty, rx_full, rx_overflow;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rxq_top u0 (
        .clk(clk), .rst(rst), .soft_flush(soft_flush),
        .push_valid(push_valid), .push_data(push_data),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_full_evt(rx_full_evt), .rx_empty(rx_empty),
        .rx_full(rx_full), .rx_overflow(rx_overflow)
    );

    // op codes: 0 push, 1 data read, 2 level read, 3 threshold write, 4 status read, 5 event level
    localparam int NV = 16;
    localparam logic [19:0] VEC [NV] = '{
        {4'd0, 8'hA1, 8'h00},
        {4'd0, 8'hB2, 8'h00},
        {4'd0, 8'hC3, 8'h00},
        {4'd2, 8'h00, 8'h02},
        {4'd4, 8'h00, 8'h00},
        {4'd3, 8'h02, 8'h00},
        {4'd5, 8'h00, 8'h01},
        {4'd3, 8'h03, 8'h00},
        {4'd5, 8'h00, 8'h00},
        {4'd1, 8'h00, 8'hA1},
        {4'd1, 8'h00, 8'hB2},
        {4'd1, 8'h00, 8'hC3},
        {4'd2, 8'h00, 8'hFF},
        {4'd4, 8'h00, 8'h40},
        {4'd1, 8'h00, 8'hC3},
        {4'd2, 8'h00, 8'hFF}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [7:0] d);
        @(negedge clk);
        push_valid = 1'b1; push_data = d;
        @(posedge clk); #1;
        push_valid = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        soft_flush = 1'b1;
        @(posedge clk); #1;
        soft_flush = 1'b0;
    endtask

    task automatic sample_pins(output logic [7:0] v);
        @(negedge clk);
        v = {4'b0, rx_full_evt, rx_empty, rx_full, rx_overflow};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        sample_pins(v);        chk("R1 pins", v, 8'b0000_0100);
        do_read(2'd2, v);      chk("R1 threshold", v, 8'h00);
        do_read(2'd1, v);      chk("R1 level", v, 8'hFF);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic [7:0] arg, exp;
            {op, arg, exp} = VEC[i];
            case (op)
                4'd0: do_push(arg);
                4'd1: begin do_read(2'd0, v); chk("R7 data", v, exp); end
                4'd2: begin do_read(2'd1, v); chk("R3 level", v, exp); end
                4'd3: do_write(2'd2, arg);
                4'd4: begin do_read(2'd3, v); chk("R6 status", v, exp); end
                default: begin
                    @(negedge clk);
                    chk("R5 event", {7'b0, rx_full_evt}, exp);
                end
            endcase
        end

        // R2 / R3 / R5 fill to capacity with threshold 15
        do_write(2'd2, 8'h0F);
        for (int i = 0; i < 15; i++) do_push(8'h10 + 8'(i));
        sample_pins(v);        chk("R5 no event at 15 bytes", v, 8'b0000_0000);
        do_push(8'h1F);
        sample_pins(v);        chk("R2 full pins", v, 8'b0000_1010);
        do_read(2'd1, v);      chk("R3 level full", v, 8'h0F);
        do_read(2'd3, v);      chk("R6 status full", v, 8'h20);

        // R8 overflow on push into full queue
        do_push(8'hEE);
        do_read(2'd3, v);      chk("R8 status overflow", v, 8'h21);
        do_read(2'd1, v);      chk("R8 level unchanged", v, 8'h0F);

        // R10 push and pop together on full queue
        @(negedge clk);
        push_valid = 1'b1; push_data = 8'h55; reg_rd = 1'b1; reg_addr = 2'd0;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        push_valid = 1'b0; reg_rd = 1'b0;
        chk("R10 head during swap", v, 8'h10);
        do_read(2'd1, v);      chk("R10 level stays full", v, 8'h0F);

        // R2 order of remaining bytes
        for (int i = 1; i < 16; i++) begin
            do_read(2'd0, v);  chk("R2 order", v, 8'h10 + 8'(i));
        end
        do_read(2'd0, v);      chk("R2 swapped byte last", v, 8'h55);
        do_read(2'd0, v);      chk("R7 empty read repeats", v, 8'h55);
        do_read(2'd1, v);      chk("R7 empty read level", v, 8'hFF);
        do_read(2'd3, v);      chk("R8 overflow sticky", v, 8'h41);

        // R4 upper bits ignored
        do_write(2'd2, 8'hF3);
        do_read(2'd2, v);      chk("R4 threshold readback", v, 8'h03);

        // R5 lowering threshold fires immediately
        do_push(8'h77);
        sample_pins(v);        chk("R5 below threshold", v, 8'b0000_0001);
        do_write(2'd2, 8'h00);
        sample_pins(v);        chk("R5 lowered threshold", v, 8'b0000_1001);

        // R9 flush with concurrent push
        @(negedge clk);
        soft_flush = 1'b1; push_valid = 1'b1; push_data = 8'h99;
        @(posedge clk); #1;
        soft_flush = 1'b0; push_valid = 1'b0;
        sample_pins(v);        chk("R9 pins after flush", v, 8'b0000_0100);
        do_write(2'd2, 8'h05);
        do_flush();
        do_read(2'd2, v);      chk("R9 threshold cleared", v, 8'h00);
        do_read(2'd3, v);      chk("R9 status after flush", v, 8'h40);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule